// File: doc/BRIEF.md
# VLIW Instruction Packet Parser

This block sits between an instruction fetch stream and a bundle decoder. It takes 32-bit instruction words, one per handshake, and groups them into packets of up to four words. Two parse bits in each word mark the packet boundary and also tag the packet as the end of one or both hardware loops. A word whose class field is zero is a constant-extender prefix. Its payload is joined to the short immediate of the next word, so that word carries a full 32-bit constant.

An upstream field-extraction stage supplies the low 6-bit immediate of each word next to the word. The parser emits one packet record per handshake. The record holds:
- the instructions packed into slots in arrival order, with extenders removed;
- a merged immediate for each slot;
- a mask of extended slots and a mask of duplex slots;
- the word count and the instruction count;
- the loop-end tags;
- two error flags.

Back-pressure rules: a word is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the packet output register is empty or is being drained in that same cycle. A presented packet stays unchanged until `out_ready` takes it. The first word after a closing word starts a new packet with cleared state.

Top module: `pkt_parser`

## Requirements
- R1: A word is consumed only when `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output field stays stable.
- R2: Bits [15:14] of a word are its parse code. Code 2'b11 closes the packet and codes 2'b00, 2'b01 and 2'b10 do not. `out_valid` rises in the cycle after the closing word is consumed.
- R3: `out_word_cnt` is the number of consumed words in the packet, extenders included, from 1 to 4. The packet length in bytes is four times this count.
- R4: If the fourth word of a packet has a parse code other than 2'b11, the packet still closes there, `out_err_oversize` is set and `out_word_cnt` is 4. The following word starts a new packet.
- R5: `out_loop_end[0]` (loop 0) is set when word 0 has code 2'b10 and word 1 has code 2'b01, 2'b10 or 2'b11. `out_loop_end[1]` (loop 1) is set when word 1 has code 2'b10 and word 0 has code 2'b01 or 2'b10. Code 2'b10 in both words sets both bits.
- R6: Loop-end tags depend only on words 0 and 1. A one-word packet never carries a tag, and the parse codes of words 2 and 3 have no effect on it.
- R7: A word with bits [31:28] equal to 4'b0000 is an extender. It counts in `out_word_cnt` but not in `out_insn_cnt`, and it takes no slot. Other words fill slots 0, 1, 2 and so on in arrival order, and unused slots read zero.
- R8: The slot immediate of a word that directly follows an extender in the same packet is {ext[27:16], ext[13:0], imm_lo}, and its `out_ext_mask` bit is set. Otherwise the slot immediate is imm_lo zero-extended to 32 bits and the mask bit is clear. Slot k occupies bits [32k+31:32k] of `out_insn` and `out_imm`.
- R9: `out_err_ext` is set when an extender is followed by another extender, or when an extender is the last word of its packet.
- R10: `out_dup_mask` bit k is set when the word in slot k has parse code 2'b00.
- R11: The word count, instruction count, loop codes, pending extender and error state are cleared at each packet start, so an extender never reaches across a packet boundary.
- R12: A synchronous active-high `rst` clears all state. After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word stream valid |
| in_ready | output | 1 | Parser can take a word |
| in_word | input | 32 | Instruction word |
| in_imm_lo | input | IMM_LO_W (6) | Low immediate extracted from `in_word` |
| out_valid | output | 1 | Packet record valid |
| out_ready | input | 1 | Consumer takes the packet record |
| out_insn | output | MAX_WORDS*32 | Instruction slots, slot 0 in the low bits |
| out_imm | output | MAX_WORDS*32 | Merged immediate per slot |
| out_ext_mask | output | MAX_WORDS | Slot immediate was extended |
| out_dup_mask | output | MAX_WORDS | Slot holds a duplex word |
| out_word_cnt | output | CNT_W (3) | Words in the packet |
| out_insn_cnt | output | CNT_W (3) | Instructions in the packet |
| out_loop_end | output | 2 | Bit 0: end of loop 0; bit 1: end of loop 1 |
| out_err_oversize | output | 1 | Packet closed at four words without a closing code |
| out_err_ext | output | 1 | Extender left unconsumed |

## Verification
Directed packets come first:
- single closing words, to separate first-word handling from accumulation;
- four-word packets with and without a closing code, to separate the size limit from the parse-code close;
- every pairing of codes in words 0 and 1, including a two-word 10/11 packet and packets whose later words carry code 10, to show the tag looks only at the first two words.

Extender cases then compare:
- an extender followed by an instruction;
- two extenders in a row;
- an extender as the closing word, followed by a plain packet that must show no leftover merge.

A long pseudo-random word stream with random output stalls follows. It exercises duplex slots, packet back-to-back starts and output holding under back-pressure against the behavioural model.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int WORD_W    = 32;
  localparam int PARSE_LO  = 14;
  localparam int CLASS_LO  = 28;
  localparam int CLASS_W   = 4;
  localparam int EXT_PAY_W = WORD_W - CLASS_W - 2;

  typedef enum logic [1:0] {
    PRS_DUPLEX = 2'b00,
    PRS_MID_A  = 2'b01,
    PRS_MID_B  = 2'b10,
    PRS_LAST   = 2'b11
  } parse_e;
endpackage

// File: rtl/pkt_word_class.sv
module pkt_word_class
  import pkt_pkg::*;
(
  input  logic [WORD_W-1:0]    word_i,
  output parse_e               parse_o,
  output logic                 is_last_o,
  output logic                 is_dup_o,
  output logic                 is_ext_o,
  output logic [EXT_PAY_W-1:0] payload_o
);
  always_comb begin
    parse_o   = parse_e'(word_i[PARSE_LO +: 2]);
    is_last_o = (parse_o == PRS_LAST);
    is_dup_o  = (parse_o == PRS_DUPLEX);
    is_ext_o  = (word_i[CLASS_LO +: CLASS_W] == '0);
    payload_o = {word_i[CLASS_LO-1:PARSE_LO+2], word_i[PARSE_LO-1:0]};
  end
endmodule

// File: rtl/pkt_loop_eval.sv
module pkt_loop_eval
  import pkt_pkg::*;
(
  input  parse_e     first_i,
  input  parse_e     second_i,
  input  logic       two_words_i,
  output logic [1:0] loop_end_o
);
  always_comb begin
    loop_end_o = 2'b00;
    if (two_words_i) begin
      loop_end_o[0] = (first_i == PRS_MID_B) && (second_i != PRS_DUPLEX);
      loop_end_o[1] = (second_i == PRS_MID_B) &&
                      ((first_i == PRS_MID_A) || (first_i == PRS_MID_B));
    end
  end
endmodule

// File: rtl/pkt_imm_merge.sv
module pkt_imm_merge
  import pkt_pkg::*;
#(
  parameter int IMM_LO_W = 6,
  localparam int IMM_W   = EXT_PAY_W + IMM_LO_W
) (
  input  logic                 pend_i,
  input  logic [EXT_PAY_W-1:0] payload_i,
  input  logic [IMM_LO_W-1:0]  imm_lo_i,
  output logic [IMM_W-1:0]     imm_o,
  output logic                 extended_o
);
  always_comb begin
    extended_o = pend_i;
    if (pend_i) imm_o = {payload_i, imm_lo_i};
    else        imm_o = {{EXT_PAY_W{1'b0}}, imm_lo_i};
  end
endmodule

// File: rtl/pkt_parser.sv
module pkt_parser
  import pkt_pkg::*;
#(
  parameter int MAX_WORDS = 4,
  parameter int IMM_LO_W  = 6,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int IMM_W    = EXT_PAY_W + IMM_LO_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WORD_W-1:0]           in_word,
  input  logic [IMM_LO_W-1:0]         in_imm_lo,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [MAX_WORDS*WORD_W-1:0] out_insn,
  output logic [MAX_WORDS*IMM_W-1:0]  out_imm,
  output logic [MAX_WORDS-1:0]        out_ext_mask,
  output logic [MAX_WORDS-1:0]        out_dup_mask,
  output logic [CNT_W-1:0]            out_word_cnt,
  output logic [CNT_W-1:0]            out_insn_cnt,
  output logic [1:0]                  out_loop_end,
  output logic                        out_err_oversize,
  output logic                        out_err_ext
);
  localparam logic [CNT_W-1:0] CAP_IDX = CNT_W'(MAX_WORDS - 1);

  // accumulator state
  logic [CNT_W-1:0]                  acc_cnt, acc_icnt;
  logic                              acc_pend, acc_err_ext;
  logic [EXT_PAY_W-1:0]              acc_pay;
  parse_e                            acc_p0, acc_p1;
  logic [MAX_WORDS-1:0][WORD_W-1:0]  acc_insn;
  logic [MAX_WORDS-1:0][IMM_W-1:0]   acc_imm;
  logic [MAX_WORDS-1:0]              acc_em, acc_dm;

  // next values
  logic [CNT_W-1:0]                  nxt_cnt, nxt_icnt;
  logic                              nxt_err_ext;
  parse_e                            nxt_p0, nxt_p1;
  logic [MAX_WORDS-1:0][WORD_W-1:0]  nxt_insn;
  logic [MAX_WORDS-1:0][IMM_W-1:0]   nxt_imm;
  logic [MAX_WORDS-1:0]              nxt_em, nxt_dm;
  logic [1:0]                        nxt_loop;

  // output registers
  logic                              out_valid_q;
  logic [MAX_WORDS-1:0][WORD_W-1:0]  out_insn_q;
  logic [MAX_WORDS-1:0][IMM_W-1:0]   out_imm_q;

  // current word
  parse_e               cur_parse;
  logic                 cur_last, cur_dup, cur_ext, cur_ext_used;
  logic [EXT_PAY_W-1:0] cur_pay;
  logic [IMM_W-1:0]     cur_imm;
  logic                 fire, at_cap, word_closes;

  pkt_word_class u_class (
    .word_i    (in_word),
    .parse_o   (cur_parse),
    .is_last_o (cur_last),
    .is_dup_o  (cur_dup),
    .is_ext_o  (cur_ext),
    .payload_o (cur_pay)
  );

  pkt_imm_merge #(.IMM_LO_W(IMM_LO_W)) u_merge (
    .pend_i     (acc_pend),
    .payload_i  (acc_pay),
    .imm_lo_i   (in_imm_lo),
    .imm_o      (cur_imm),
    .extended_o (cur_ext_used)
  );

  assign in_ready    = !out_valid_q || out_ready;
  assign fire        = in_valid && in_ready;
  assign at_cap      = (acc_cnt == CAP_IDX);
  assign word_closes = cur_last || at_cap;

  always_comb begin
    nxt_cnt     = acc_cnt + CNT_W'(1);
    nxt_icnt    = cur_ext ? acc_icnt : acc_icnt + CNT_W'(1);
    nxt_p0      = (acc_cnt == '0) ? cur_parse : acc_p0;
    nxt_p1      = (acc_cnt == CNT_W'(1)) ? cur_parse : acc_p1;
    nxt_err_ext = acc_err_ext | (cur_ext & (acc_pend | word_closes));
  end

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
    logic hit;
    assign hit         = !cur_ext && (acc_icnt == CNT_W'(g));
    assign nxt_insn[g] = hit ? in_word      : acc_insn[g];
    assign nxt_imm[g]  = hit ? cur_imm      : acc_imm[g];
    assign nxt_em[g]   = hit ? cur_ext_used : acc_em[g];
    assign nxt_dm[g]   = hit ? cur_dup      : acc_dm[g];
  end

  pkt_loop_eval u_loop (
    .first_i     (nxt_p0),
    .second_i    (nxt_p1),
    .two_words_i (nxt_cnt >= CNT_W'(2)),
    .loop_end_o  (nxt_loop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt     <= '0;
      acc_icnt    <= '0;
      acc_pend    <= 1'b0;
      acc_err_ext <= 1'b0;
      acc_pay     <= '0;
      acc_p0      <= PRS_DUPLEX;
      acc_p1      <= PRS_DUPLEX;
      acc_insn    <= '0;
      acc_imm     <= '0;
      acc_em      <= '0;
      acc_dm      <= '0;
      out_valid_q      <= 1'b0;
      out_insn_q       <= '0;
      out_imm_q        <= '0;
      out_ext_mask     <= '0;
      out_dup_mask     <= '0;
      out_word_cnt     <= '0;
      out_insn_cnt     <= '0;
      out_loop_end     <= '0;
      out_err_oversize <= 1'b0;
      out_err_ext      <= 1'b0;
    end else begin
      if (out_valid_q && out_ready) out_valid_q <= 1'b0;
      if (fire) begin
        if (word_closes) begin
          out_valid_q      <= 1'b1;
          out_insn_q       <= nxt_insn;
          out_imm_q        <= nxt_imm;
          out_ext_mask     <= nxt_em;
          out_dup_mask     <= nxt_dm;
          out_word_cnt     <= nxt_cnt;
          out_insn_cnt     <= nxt_icnt;
          out_loop_end     <= nxt_loop;
          out_err_oversize <= at_cap && !cur_last;
          out_err_ext      <= nxt_err_ext;
          acc_cnt     <= '0;
          acc_icnt    <= '0;
          acc_pend    <= 1'b0;
          acc_err_ext <= 1'b0;
          acc_pay     <= '0;
          acc_p0      <= PRS_DUPLEX;
          acc_p1      <= PRS_DUPLEX;
          acc_insn    <= '0;
          acc_imm     <= '0;
          acc_em      <= '0;
          acc_dm      <= '0;
        end else begin
          acc_cnt     <= nxt_cnt;
          acc_icnt    <= nxt_icnt;
          acc_pend    <= cur_ext;
          acc_err_ext <= nxt_err_ext;
          acc_pay     <= cur_ext ? cur_pay : acc_pay;
          acc_p0      <= nxt_p0;
          acc_p1      <= nxt_p1;
          acc_insn    <= nxt_insn;
          acc_imm     <= nxt_imm;
          acc_em      <= nxt_em;
          acc_dm      <= nxt_dm;
        end
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_insn  = out_insn_q;
  assign out_imm   = out_imm_q;

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_insn) && $stable(out_imm)
      && $stable(out_word_cnt) && $stable(out_loop_end));
  // R3
  word_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word_cnt >= CNT_W'(1)) && (out_word_cnt <= CNT_W'(MAX_WORDS)));
  // R4
  oversize_len_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err_oversize |-> out_word_cnt == CNT_W'(MAX_WORDS));
  // R6
  loop_two_words_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_loop_end != 2'b00) |-> out_word_cnt >= CNT_W'(2));
  // R7
  insn_le_words_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_insn_cnt <= out_word_cnt);
  // R2
  acc_below_cap_chk: assert property (@(posedge clk) disable iff (rst)
    acc_cnt < CNT_W'(MAX_WORDS));
  // R11
  fresh_start_chk: assert property (@(posedge clk) disable iff (rst)
    fire && word_closes |=> acc_cnt == '0 && !acc_pend && !acc_err_ext);
endmodule

// File: tb/pkt_parser_bench.sv
module pkt_parser_bench;
  localparam int MW = 4;

  typedef struct packed {
    logic [127:0] insn;
    logic [127:0] imm;
    logic [3:0]   em;
    logic [3:0]   dm;
    logic [2:0]   wc;
    logic [2:0]   ic;
    logic [1:0]   le;
    logic         ov;
    logic         ee;
  } pkt_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_word = '0;
  logic [5:0]  in_imm_lo = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [127:0] out_insn, out_imm;
  logic [3:0] out_ext_mask, out_dup_mask;
  logic [2:0] out_word_cnt, out_insn_cnt;
  logic [1:0] out_loop_end;
  logic out_err_oversize, out_err_ext;

  int errors = 0;
  int checks = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;
  string stage = "reset";

  pkt_t  expq[$];
  string tagq[$];

  int m_cnt = 0, m_icnt = 0;
  bit m_pend = 1'b0;
  logic [25:0] m_pay = '0;
  logic [1:0] m_p0 = '0, m_p1 = '0;
  pkt_t m_pk = '0;

  always #2.5 clk = ~clk;

  pkt_parser u_pkt_parser (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_imm_lo(in_imm_lo),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_imm(out_imm),
    .out_ext_mask(out_ext_mask), .out_dup_mask(out_dup_mask),
    .out_word_cnt(out_word_cnt), .out_insn_cnt(out_insn_cnt),
    .out_loop_end(out_loop_end),
    .out_err_oversize(out_err_oversize), .out_err_ext(out_err_ext)
  );

  task automatic chk(input string req, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] cls, input logic [1:0] pr,
                                     input logic [25:0] pay);
    return {cls, pay[25:14], pr, pay[13:0]};
  endfunction

  // behavioural reference: updated once per consumed word
  task automatic model_accept(input logic [31:0] w, input logic [5:0] lo);
    logic [1:0] pr;
    bit ext, closes;
    pr = w[15:14];
    ext = (w[31:28] == 4'd0);
    closes = (pr == 2'b11) || (m_cnt == MW - 1);
    if (m_cnt == 0) m_p0 = pr;
    if (m_cnt == 1) m_p1 = pr;
    if (ext) begin
      if (m_pend || closes) m_pk.ee = 1'b1;
      m_pend = 1'b1;
      m_pay = {w[27:16], w[13:0]};
    end else begin
      m_pk.insn[m_icnt*32 +: 32] = w;
      m_pk.imm[m_icnt*32 +: 32]  = m_pend ? {m_pay, lo} : {26'd0, lo};
      m_pk.em[m_icnt] = m_pend;
      m_pk.dm[m_icnt] = (pr == 2'b00);
      m_icnt++;
      m_pend = 1'b0;
    end
    m_cnt++;
    if (closes) begin
      m_pk.wc = 3'(m_cnt);
      m_pk.ic = 3'(m_icnt);
      m_pk.ov = (pr != 2'b11);
      m_pk.le = 2'b00;
      if (m_cnt >= 2) begin
        if (m_p0 == 2'b10 && m_p1 == 2'b10)                       m_pk.le = 2'b11;
        else if (m_p0 == 2'b10 && (m_p1 == 2'b01 || m_p1 == 2'b11)) m_pk.le = 2'b01;
        else if (m_p0 == 2'b01 && m_p1 == 2'b10)                  m_pk.le = 2'b10;
      end
      expq.push_back(m_pk);
      tagq.push_back(stage);
      m_pk = '0; m_cnt = 0; m_icnt = 0; m_pend = 1'b0; m_p0 = '0; m_p1 = '0;
    end
  endtask

  task automatic send(input logic [3:0] cls, input logic [1:0] pr, input logic [25:0] pay,
                      input logic [5:0] lo);
    bit taken;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_word = mk(cls, pr, pay);
    in_imm_lo = lo;
    taken = 1'b0;
    while (!taken) begin
      @(negedge clk);
      if (in_ready) taken = 1'b1;
    end
    model_accept(in_word, in_imm_lo);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // output back-pressure
  always @(posedge clk) begin
    #1;
    if (bp_en) out_ready = ($urandom % 3) != 0;
    else       out_ready = 1'b1;
  end

  // per-cycle comparison
  logic had_hold = 1'b0;
  logic [127:0] h_insn, h_imm;
  logic [2:0] h_wc;
  logic [1:0] h_le;
  always @(negedge clk) begin
    if (!rst) begin
      // R1: ready follows output register occupancy
      chk("R1", "in_ready", 256'(in_ready), 256'(!out_valid || out_ready));
      if (had_hold) begin
        // R1: held record stable under back-pressure
        chk("R1", "held valid", 256'(out_valid), 256'(1));
        chk("R1", "held record", {out_insn, out_imm} ^ 256'({h_wc, h_le}),
            {h_insn, h_imm} ^ 256'({out_word_cnt, out_loop_end}));
      end
      had_hold = out_valid && !out_ready;
      h_insn = out_insn; h_imm = out_imm; h_wc = out_word_cnt; h_le = out_loop_end;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk("R2", "unexpected packet", 256'(1), 256'(0));
        end else begin
          pkt_t e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk("R2", {t, " insn slots"}, 256'(out_insn), 256'(e.insn));
          chk("R3", {t, " word count"}, 256'(out_word_cnt), 256'(e.wc));
          chk("R7", {t, " insn count"}, 256'(out_insn_cnt), 256'(e.ic));
          chk("R8", {t, " imm"}, 256'(out_imm), 256'(e.imm));
          chk("R8", {t, " ext mask"}, 256'(out_ext_mask), 256'(e.em));
          chk("R10", {t, " dup mask"}, 256'(out_dup_mask), 256'(e.dm));
          chk("R5", {t, " loop end"}, 256'(out_loop_end), 256'(e.le));
          chk("R4", {t, " oversize"}, 256'(out_err_oversize), 256'(e.ov));
          chk("R9", {t, " ext error"}, 256'(out_err_ext), 256'(e.ee));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12
    chk("R12", "reset out_valid", 256'(out_valid), 256'(0));
    chk("R12", "reset in_ready", 256'(in_ready), 256'(1));

    stage = "R2 single";
    send(4'h1, 2'b11, 26'h0000123, 6'h05);
    send(4'h7, 2'b11, 26'h3ffffff, 6'h3f);

    stage = "R3 four words";
    send(4'h2, 2'b01, 26'h1, 6'h01);
    send(4'h3, 2'b01, 26'h2, 6'h02);
    send(4'h4, 2'b01, 26'h3, 6'h03);
    send(4'h5, 2'b11, 26'h4, 6'h04);

    stage = "R5 loop0";
    send(4'h1, 2'b10, 26'h10, 6'h0);
    send(4'h1, 2'b01, 26'h11, 6'h0);
    send(4'h1, 2'b11, 26'h12, 6'h0);
    stage = "R5 loop0 two words";
    send(4'h1, 2'b10, 26'h13, 6'h0);
    send(4'h1, 2'b11, 26'h14, 6'h0);
    stage = "R5 loop1";
    send(4'h1, 2'b01, 26'h20, 6'h0);
    send(4'h1, 2'b10, 26'h21, 6'h0);
    send(4'h1, 2'b11, 26'h22, 6'h0);
    stage = "R5 both loops";
    send(4'h1, 2'b10, 26'h30, 6'h0);
    send(4'h1, 2'b10, 26'h31, 6'h0);
    send(4'h1, 2'b11, 26'h32, 6'h0);

    stage = "R6 later words ignored";
    send(4'h1, 2'b01, 26'h40, 6'h0);
    send(4'h1, 2'b01, 26'h41, 6'h0);
    send(4'h1, 2'b10, 26'h42, 6'h0);
    send(4'h1, 2'b11, 26'h43, 6'h0);

    stage = "R4 oversize";
    send(4'h8, 2'b01, 26'h50, 6'h0);
    send(4'h8, 2'b10, 26'h51, 6'h0);
    send(4'h8, 2'b01, 26'h52, 6'h0);
    send(4'h8, 2'b01, 26'h53, 6'h0);
    stage = "R4 after oversize";
    send(4'h9, 2'b11, 26'h54, 6'h09);

    stage = "R8 extender merge";
    send(4'h0, 2'b01, 26'h2abcdef, 6'h0);
    send(4'h6, 2'b11, 26'h0, 6'h2a);

    stage = "R9 double extender";
    send(4'h0, 2'b01, 26'h1111111, 6'h0);
    send(4'h0, 2'b01, 26'h2222222, 6'h0);
    send(4'h6, 2'b11, 26'h0, 6'h11);

    stage = "R9 extender closes";
    send(4'h6, 2'b01, 26'h5, 6'h01);
    send(4'h0, 2'b11, 26'h3333333, 6'h0);
    stage = "R11 fresh state";
    send(4'h6, 2'b11, 26'h6, 6'h15);

    stage = "R10 duplex";
    send(4'hc, 2'b00, 26'h77, 6'h07);
    send(4'hd, 2'b11, 26'h78, 6'h08);

    stage = "R1 random stream";
    bp_en = 1'b1;
    for (int i = 0; i < 500; i++) begin
      logic [3:0] c;
      c = ($urandom % 6 == 0) ? 4'h0 : 4'($urandom);
      send(c, 2'($urandom), 26'($urandom), 6'($urandom));
    end
    send(4'h1, 2'b11, 26'h0, 6'h0);

    for (int w = 0; w < 200 && expq.size() != 0; w++) @(posedge clk);
    bp_en = 1'b0;
    repeat (5) @(posedge clk);
    chk("R2", "packets left", 256'(expq.size()), 256'(0));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule